// File: doc/BRIEF.md
# Error Status Register with Terminal Flag

This block collects error events from a serial-bus remote interface into one sticky status register. Six error sources elsewhere in the interface pulse for one cycle when they detect a fault. The block itself generates the remaining two error events: an operation that runs too long, and a message that ends successfully before its operation has finished. Each event sets its own bit, and the bit stays set until the host reads the register. The read returns the value in the same cycle and clears the register at the following clock edge. An event that arrives in the same cycle as the read is kept, so no error can slip through between the read and the clear.

The terminal flag is high whenever any bit is set. In the first cycle that the register holds a non-zero value after being zero, the block issues a one-cycle interface reset request. A built-in duration timer is started by the operation start strobe and stopped by the operation done strobe. Its limit is a parameter, and the default of 2000 cycles is 100 µs at 20 MHz.

Top module: `err_status_reg`

## Requirements
- R1: After reset the read data, the terminal flag and the reset request are all 0.
- R2: Read data bits 15 down to 8 are always 0.
- R3: A one-cycle pulse on `err_pulse_i[i]`, for i from 0 to 5, sets status bit i from the next cycle onward. The bits are: 0 receive sequencer illegal state, 1 transmit sequencer illegal state, 2 transmit FIFO read while empty, 3 receive FIFO written while full, 4 echo fault on channel A, 5 echo fault on channel B.
- R4: A set bit stays set, whatever the other inputs do, until a read.
- R5: While `rd_stb_i` is high, `rd_data_o` shows the current status. After that clock edge the status is 0, apart from the bits covered by R6.
- R6: An error event in the same cycle as a read is set in the status after the read.
- R7: `term_flag_o` is 1 exactly when the status is non-zero.
- R8: `if_rst_req_o` is high for exactly one cycle: the first cycle in which the status is non-zero after a cycle in which it was zero.
- R9: Bit 7 (overtime) sets when an operation lasts more than LIMIT cycles. The duration is counted from the start cycle to the done cycle, and one that lasts exactly LIMIT cycles does not set the bit. The bit sets at most once per operation, and it sets even if the operation never ends.
- R10: Bit 6 (overrun) sets when `msg_ok_i` is high while an operation is in progress and `op_done_i` is low in that cycle. `msg_ok_i` has no effect when no operation is in progress, or when the done strobe arrives in the same cycle.
- R11: A start strobe during an operation restarts the duration count from that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_pulse_i | input | 6 | Error event pulses for status bits 0 to 5 |
| op_start_i | input | 1 | Operation start strobe |
| op_done_i | input | 1 | Operation done strobe |
| msg_ok_i | input | 1 | Message ended successfully |
| rd_stb_i | input | 1 | Host read strobe (clears the register) |
| rd_data_o | output | 16 | Status read data |
| term_flag_o | output | 1 | Terminal flag, high while any error is held |
| if_rst_req_o | output | 1 | One-cycle interface reset request |

## Verification
The hardest situations to reach are the edges of the duration window and the race between a read and a new event. The bench builds the window edge by running one operation for each duration from LIMIT-2 to LIMIT+3 cycles, with the limit shrunk to 12. It stops each operation exactly on the target cycle and compares bit 7 with the rule duration > LIMIT. The race is reached by pulsing one error pattern while the host reads a different, previously loaded pattern. The bench then checks that only the new pattern survives and that no second reset request appears.

// File: rtl/err_status_pkg.sv
package err_status_pkg;
  localparam int STAT_W       = 16;
  localparam int NUM_FLAGS    = 8;
  localparam int EXT_FLAGS    = 6;
  localparam int BIT_OVERRUN  = 6;
  localparam int BIT_OVERTIME = 7;

  // Next value of the sticky bank: a read wipes held bits, new events survive
  function automatic logic [NUM_FLAGS-1:0] next_flags(
    input logic [NUM_FLAGS-1:0] held,
    input logic                 clr,
    input logic [NUM_FLAGS-1:0] set_v);
    next_flags = (clr ? '0 : held) | set_v;
  endfunction

  // Zero-extend flag bank to the register width
  function automatic logic [STAT_W-1:0] widen(input logic [NUM_FLAGS-1:0] f);
    widen = {{(STAT_W-NUM_FLAGS){1'b0}}, f};
  endfunction
endpackage

// File: rtl/op_timer.sv
module op_timer #(
  parameter int LIMIT = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic done_i,
  input  logic ok_i,
  output logic active_o,
  output logic [$clog2(LIMIT+1)-1:0] cnt_o,
  output logic overtime_o,
  output logic overrun_o
);
  localparam int CW = $clog2(LIMIT+1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic          active_q;
  logic          fired_q;
  logic [CW-1:0] cnt_q;

  // Elapsed cycles since start reach LIMIT+1 in the cycle where cnt_q == LIMIT
  assign overtime_o = active_q && (cnt_q == LIM) && !fired_q;
  assign overrun_o  = active_q && ok_i && !done_i;
  assign active_o   = active_q;
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      fired_q  <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      fired_q  <= 1'b0;
      cnt_q    <= '0;
    end else begin
      if (done_i) active_q <= 1'b0;
      if (overtime_o) fired_q <= 1'b1;
      if (active_q && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/flag_bank.sv
module flag_bank
  import err_status_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_i,
  input  logic [NUM_FLAGS-1:0] set_i,
  output logic [NUM_FLAGS-1:0] flags_o
);
  logic [NUM_FLAGS-1:0] flags_q;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) flags_q[g] <= 1'b0;
      else        flags_q[g] <= next_flags(flags_q, clr_i, set_i)[g];
    end
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/rst_req_gen.sv
module rst_req_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic any_i,
  output logic req_o
);
  logic any_d;

  always_ff @(posedge clk) begin
    if (!rst_n) any_d <= 1'b0;
    else        any_d <= any_i;
  end

  assign req_o = any_i && !any_d;
endmodule

// File: rtl/err_status_reg.sv
module err_status_reg
  import err_status_pkg::*;
#(
  parameter int OVERTIME_CYCLES = 2000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [EXT_FLAGS-1:0] err_pulse_i,
  input  logic                 op_start_i,
  input  logic                 op_done_i,
  input  logic                 msg_ok_i,
  input  logic                 rd_stb_i,
  output logic [STAT_W-1:0]    rd_data_o,
  output logic                 term_flag_o,
  output logic                 if_rst_req_o
);
  localparam int CW = $clog2(OVERTIME_CYCLES+1);

  logic                 tmr_active;
  logic [CW-1:0]        tmr_cnt;
  logic                 ev_overtime;
  logic                 ev_overrun;
  logic [NUM_FLAGS-1:0] set_vec;
  logic [NUM_FLAGS-1:0] flags;

  op_timer #(.LIMIT(OVERTIME_CYCLES)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (op_start_i),
    .done_i     (op_done_i),
    .ok_i       (msg_ok_i),
    .active_o   (tmr_active),
    .cnt_o      (tmr_cnt),
    .overtime_o (ev_overtime),
    .overrun_o  (ev_overrun)
  );

  assign set_vec = {ev_overtime, ev_overrun, err_pulse_i};

  flag_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (rd_stb_i),
    .set_i   (set_vec),
    .flags_o (flags)
  );

  assign rd_data_o   = widen(flags);
  assign term_flag_o = |flags;

  rst_req_gen u_req (
    .clk   (clk),
    .rst_n (rst_n),
    .any_i (term_flag_o),
    .req_o (if_rst_req_o)
  );
endmodule

// File: rtl/err_status_chk.sv
module err_status_chk #(
  parameter int LIMIT = 2000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_stb_i,
  input logic [15:0] rd_data_o,
  input logic        term_flag_o,
  input logic        if_rst_req_o,
  input logic [7:0]  set_vec,
  input logic        tmr_active,
  input logic [$clog2(LIMIT+1)-1:0] tmr_cnt,
  input logic        ev_overtime
);
  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[15:8] == 8'h00);
  // R4
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb_i |=> ((rd_data_o[7:0] & $past(rd_data_o[7:0])) == $past(rd_data_o[7:0])));
  // R5
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_i && set_vec == 8'h00) |=> rd_data_o == 16'h0000);
  // R6
  keep_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb_i |=> rd_data_o[7:0] == $past(set_vec));
  // R8
  req_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(term_flag_o) |-> if_rst_req_o);
  // R8
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    if_rst_req_o |=> !if_rst_req_o);
  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_active |-> tmr_cnt <= ($clog2(LIMIT+1))'(LIMIT));
  // R9
  overtime_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overtime |=> !ev_overtime);
endmodule

bind err_status_reg err_status_chk #(.LIMIT(OVERTIME_CYCLES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_stb_i     (rd_stb_i),
  .rd_data_o    (rd_data_o),
  .term_flag_o  (term_flag_o),
  .if_rst_req_o (if_rst_req_o),
  .set_vec      (set_vec),
  .tmr_active   (tmr_active),
  .tmr_cnt      (tmr_cnt),
  .ev_overtime  (ev_overtime)
);

// File: tb/test_err_status_reg.sv
module test_err_status_reg;
  localparam int L = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  err = '0;
  logic        start = 1'b0, done = 1'b0, ok = 1'b0, rd = 1'b0;
  logic [15:0] rdata;
  logic        term, req;
  int          n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  err_status_reg #(.OVERTIME_CYCLES(L)) i_err_status_reg (
    .clk(clk), .rst_n(rst_n), .err_pulse_i(err), .op_start_i(start),
    .op_done_i(done), .msg_ok_i(ok), .rd_stb_i(rd), .rd_data_o(rdata),
    .term_flag_o(term), .if_rst_req_o(req));

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  // Read and clear; expects the given value during the read
  task automatic read_clear(input string req_tag, input logic [15:0] exp);
    rd = 1'b1;
    chk(req_tag, 32'(rdata), 32'(exp));
    step();
    rd = 1'b0;
  endtask

  initial begin
    #200000;
    n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    step(); step(); step();
    // R1 reset state
    chk("R1 data", 32'(rdata), 0);
    chk("R1 term", 32'(term), 0);
    chk("R1 req", 32'(req), 0);
    rst_n = 1'b1;
    step();

    // R3 R5 R7 R8 sweep over every external pattern
    for (int p = 1; p < 64; p++) begin
      err = 6'(p);
      step();
      err = '0;
      chk("R3 bits", 32'(rdata), 32'(p));
      chk("R2 upper", 32'(rdata[15:8]), 0);
      chk("R7 term set", 32'(term), 1);
      chk("R8 req pulse", 32'(req), 1);
      step();
      chk("R8 req single", 32'(req), 0);
      chk("R4 held", 32'(rdata), 32'(p));
      read_clear("R5 read value", 16'(p));
      chk("R5 cleared", 32'(rdata), 0);
      chk("R7 term clear", 32'(term), 0);
    end

    // R4 accumulation of separate pulses
    err = 6'h01; step(); err = 6'h20; step(); err = '0; step();
    chk("R4 accumulate", 32'(rdata), 32'h21);
    chk("R8 no second req", 32'(req), 0);

    // R6 new event during read survives, old bits dropped
    for (int b = 0; b < 6; b++) begin
      err = 6'(1 << b);
      rd  = 1'b1;
      step();
      err = '0; rd = 1'b0;
      chk("R6 kept", 32'(rdata), 32'(1 << b));
      chk("R8 no req on race", 32'(req), 0);
      err = 6'h21; step(); err = '0;
    end
    read_clear("R5 final", 16'h21);
    step();

    // R9 overtime window sweep
    for (int d = L - 2; d <= L + 3; d++) begin
      start = 1'b1; step(); start = 1'b0;
      for (int k = 1; k < d; k++) step();
      done = 1'b1; step(); done = 1'b0;
      chk($sformatf("R9 duration %0d", d), 32'(rdata), (d > L) ? 32'h80 : 32'h0);
      if (d > L) read_clear("R9 clear", 16'h80);
      step();
    end
    // R9 never-ending operation sets once
    start = 1'b1; step(); start = 1'b0;
    for (int k = 1; k <= L + 1; k++) step();
    chk("R9 no done", 32'(rdata), 32'h80);
    read_clear("R9 open", 16'h80);
    for (int k = 0; k < 5; k++) step();
    chk("R9 once", 32'(rdata), 0);
    done = 1'b1; step(); done = 1'b0;

    // R11 restart extends the window
    start = 1'b1; step(); start = 1'b0;
    for (int k = 1; k < L - 1; k++) step();
    start = 1'b1; step(); start = 1'b0;
    for (int k = 1; k < L; k++) step();
    done = 1'b1; step(); done = 1'b0;
    chk("R11 restart", 32'(rdata), 0);

    // R10 overrun cases
    ok = 1'b1; step(); ok = 1'b0;
    chk("R10 idle ok", 32'(rdata), 0);
    start = 1'b1; step(); start = 1'b0; step();
    ok = 1'b1; done = 1'b1; step(); ok = 1'b0; done = 1'b0;
    chk("R10 ok with done", 32'(rdata), 0);
    start = 1'b1; step(); start = 1'b0; step(); step();
    ok = 1'b1; step(); ok = 1'b0;
    chk("R10 overrun", 32'(rdata), 32'h40);
    chk("R8 overrun req", 32'(req), 1);
    done = 1'b1; step(); done = 1'b0;
    read_clear("R10 clear", 16'h40);
    chk("R5 after overrun", 32'(rdata), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule